// File: doc/BRIEF.md
# Pixel Color Space Converter

This block recolors a stream of 8-bit, three-component pixels with a programmable 3x3 matrix plus a per-row constant. One pixel may enter on every clock. The valid, horizontal sync, vertical sync and data-enable flags travel beside the pixel and leave with it after the same fixed delay. The matrix can map full-range RGB to limited-range RGB, or RGB to BT.601 or BT.709 YCbCr. The bench loads each of these as a set of values, so none of them is hard-wired.

Coefficients are written one byte at a time through a small write port into a pending bank. The pending bank is copied into the working bank only when a frame starts, which is a rising edge on the incoming vertical sync. Because of this, no frame is ever processed with two different matrices. A per-pixel enable selects between the converted result and the untouched input, with identical latency. A swap control exchanges the first and last output components.

Top module: `csc_matrix`

## Requirements
- R1: While reset is held and right after it, out_valid, out_hsync, out_vsync, out_de and out_pix are all zero.
- R2: out_valid, out_hsync, out_vsync and out_de repeat in_valid, in_hsync, in_vsync and in_de exactly three clock edges later.
- R3: When csc_en is 0 and swap_en is 0, out_pix equals the in_pix of three edges earlier.
- R4: Byte address 2k holds bits 15:8 and byte address 2k+1 holds bits 7:0 of word k (k = 0..11). Word k belongs to output row k/4, at column k%4. Columns 0..2 weight input components 0..2, and column 3 is the row constant. Component n of a pixel occupies bits 8n+7:8n. Writes to addresses above 23 are ignored.
- R5: Bit 12 of a word set to 1 makes the word negative. The magnitude is in bits 11:0, and bits 15:13 are ignored. Columns 0..2 are weights with 10 fractional bits (0x400 = 1.0). The row constant is an integer.
- R6: A row result is the sum of weighted inputs plus the constant, rounded to the nearest integer, with exact halves rounded upward (toward +infinity).
- R7: A row result below 0 gives 0, and a result above 255 gives 255.
- R8: With 0x036F on the diagonal, zeros elsewhere and a constant of 16 in every row, input 0 gives 16 and input 255 gives 235 on every component.
- R9: When swap_en is 1, output components 0 and 2 are exchanged. This holds with the conversion enabled and in bypass alike.
- R10: Byte writes do not change results until the next rising edge of in_vsync. The pixel presented together with that rising edge already uses the new matrix.
- R11: With BT.601 weights, whose chroma rows sum to zero, and chroma constants of 128, any gray input gives exactly 128 on both chroma components. White gives 235 luma when the luma constant is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csc_en | input | 1 | 1 converts the pixel, 0 passes it through |
| swap_en | input | 1 | 1 exchanges output components 0 and 2 |
| cfg_wr_en | input | 1 | Coefficient byte write strobe |
| cfg_addr | input | 5 | Coefficient byte address, 0..23 |
| cfg_data | input | 8 | Coefficient byte value |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync; a rising edge starts a frame |
| in_de | input | 1 | Input data enable |
| in_pix | input | 24 | Input pixel, component n at bits 8n+7:8n |
| out_valid | output | 1 | Delayed valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |
| out_pix | output | 24 | Converted or bypassed pixel |

## Verification
Every pixel result and every sideband flag is due on the third rising edge after the input is captured. The bench drives inputs on the falling edge and counts three rising edges. It then samples on the following falling edge, and for the sideband it also confirms the flag is still low one edge earlier. A coefficient byte lands in the pending bank after one edge, but it is visible only through a pixel sent with or after a vertical sync rise. The bench therefore sends a pixel before that rise to confirm the old matrix still applies, and a second pixel on the same cycle as the rise to confirm the new one applies.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int PIX_W    = 8;
    localparam int N_CH     = 3;
    localparam int N_COL    = N_CH + 1;
    localparam int COEF_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int MAG_W    = 12;
    localparam int SIGN_BIT = 12;
    localparam int FRAC_W   = 10;
    localparam int N_WORDS  = N_CH * N_COL;
    localparam int N_BYTES  = N_WORDS * (COEF_W / BYTE_W);
    localparam int ADDR_W   = $clog2(N_BYTES);
    localparam int ACC_W    = PIX_W + MAG_W + FRAC_W + 4;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0]                 chan_t;
    typedef logic [N_CH-1:0][PIX_W-1:0]       pix_t;
    typedef logic [COEF_W-1:0]                word_t;
    typedef logic [N_COL-1:0][COEF_W-1:0]     row_coef_t;
    typedef row_coef_t [N_CH-1:0]             coef_bank_t;
    typedef logic signed [ACC_W-1:0]          acc_t;

    typedef struct packed {
        logic valid;
        logic hsync;
        logic vsync;
        logic de;
    } side_t;

    typedef struct packed {
        logic en;
        logic swap;
    } mode_t;

    // Sign-magnitude word to a signed value.
    function automatic acc_t word_value(word_t w);
        acc_t mag;
        mag = acc_t'({1'b0, w[MAG_W-1:0]});
        return w[SIGN_BIT] ? -mag : mag;
    endfunction

    function automatic chan_t clamp_chan(acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return chan_t'(PIX_MAX);
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              frame_start,
    output coef_bank_t        bank
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_BYTES - 1);

    logic [N_BYTES-1:0][BYTE_W-1:0] pend_q;
    coef_bank_t                     pend_w;
    coef_bank_t                     work_q;

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        assign pend_w[k / N_COL][k % N_COL] = {pend_q[2*k], pend_q[2*k+1]};
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (wr_en && wr_addr <= LAST_ADDR)
            pend_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            work_q <= '0;
        else if (frame_start)
            work_q <= pend_w;
    end

    // The pixel arriving with the frame start already sees the new bank.
    assign bank = frame_start ? pend_w : work_q;

    // R10
    work_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(work_q));

    // R4
    byte_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr <= LAST_ADDR) |=> pend_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pix_t      pix,
    input  row_coef_t coefs,
    output acc_t      result
);
    localparam acc_t HALF = acc_t'(1) <<< (FRAC_W - 1);

    logic [N_CH-1:0][ACC_W-1:0] prod_q;
    acc_t                       ofs_q;
    acc_t                       total;

    // Stage 1: weight every component, scale the constant.
    for (genvar j = 0; j < N_CH; j++) begin : g_mul
        always_ff @(posedge clk) begin
            if (rst)
                prod_q[j] <= '0;
            else
                prod_q[j] <= word_value(coefs[j]) * acc_t'({1'b0, pix[j]});
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ofs_q <= '0;
        else
            ofs_q <= word_value(coefs[N_COL-1]) <<< FRAC_W;
    end

    // Stage 2: accumulate, round half up, drop the fraction.
    always_comb begin
        total = ofs_q + HALF;
        for (int j = 0; j < N_CH; j++)
            total = total + $signed(prod_q[j]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else
            result <= total >>> FRAC_W;
    end

endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage
    import csc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CH-1:0][ACC_W-1:0] sums,
    input  pix_t                       bypass,
    input  mode_t                      mode,
    input  side_t                      side_in,
    output pix_t                       pix_out,
    output side_t                      side_out
);
    pix_t conv;
    pix_t sel;
    pix_t ordered;

    for (genvar i = 0; i < N_CH; i++) begin : g_clamp
        assign conv[i] = clamp_chan($signed(sums[i]));
    end

    always_comb begin
        sel     = mode.en ? conv : bypass;
        ordered = sel;
        if (mode.swap) begin
            ordered[0]      = sel[N_CH-1];
            ordered[N_CH-1] = sel[0];
        end
    end

    // Stage 3: register the final pixel with its flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out  <= '0;
            side_out <= '0;
        end else begin
            pix_out  <= ordered;
            side_out <= side_in;
        end
    end

    // R7
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.en && !mode.swap && $signed(sums[0]) < 0) |=> pix_out[0] == '0);

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      csc_en,
    input  logic                      swap_en,
    input  logic                      cfg_wr_en,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [BYTE_W-1:0]         cfg_data,
    input  logic                      in_valid,
    input  logic                      in_hsync,
    input  logic                      in_vsync,
    input  logic                      in_de,
    input  logic [N_CH*PIX_W-1:0]     in_pix,
    output logic                      out_valid,
    output logic                      out_hsync,
    output logic                      out_vsync,
    output logic                      out_de,
    output logic [N_CH*PIX_W-1:0]     out_pix
);
    side_t side_in, side_d1, side_d2, side_q;
    mode_t mode_in, mode_d1, mode_d2;
    pix_t  pix_in, pix_d1, pix_d2, pix_q;
    logic  vs_prev;
    logic  frame_start;
    logic  [1:0] warm_q;

    coef_bank_t                 bank;
    logic [N_CH-1:0][ACC_W-1:0] sums;

    assign pix_in      = in_pix;
    assign side_in     = '{valid: in_valid, hsync: in_hsync, vsync: in_vsync, de: in_de};
    assign mode_in     = '{en: csc_en, swap: swap_en};
    assign frame_start = in_vsync & ~vs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev <= 1'b0;
            side_d1 <= '0;
            side_d2 <= '0;
            mode_d1 <= '0;
            mode_d2 <= '0;
            pix_d1  <= '0;
            pix_d2  <= '0;
            warm_q  <= '0;
        end else begin
            vs_prev <= in_vsync;
            side_d1 <= side_in;
            side_d2 <= side_d1;
            mode_d1 <= mode_in;
            mode_d2 <= mode_d1;
            pix_d1  <= pix_in;
            pix_d2  <= pix_d1;
            if (warm_q != 2'd3)
                warm_q <= warm_q + 2'd1;
        end
    end

    csc_coef_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_data),
        .frame_start (frame_start),
        .bank        (bank)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_row
        csc_row u_row (
            .clk    (clk),
            .rst    (rst),
            .pix    (pix_in),
            .coefs  (bank[i]),
            .result (sums[i])
        );
    end

    csc_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .sums     (sums),
        .bypass   (pix_d2),
        .mode     (mode_d2),
        .side_in  (side_d2),
        .pix_out  (pix_q),
        .side_out (side_q)
    );

    assign out_pix   = pix_q;
    assign out_valid = side_q.valid;
    assign out_hsync = side_q.hsync;
    assign out_vsync = side_q.vsync;
    assign out_de    = side_q.de;

    // R2
    side_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |->
        {out_valid, out_hsync, out_vsync, out_de} ==
        $past({in_valid, in_hsync, in_vsync, in_de}, 3));

    // R3
    bypass_path_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3 && !$past(csc_en, 3) && !$past(swap_en, 3) && $past(in_valid, 3))
        |-> out_pix == $past(in_pix, 3));

endmodule

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        csc_en, swap_en, cfg_wr_en;
    logic [4:0]  cfg_addr;
    logic [7:0]  cfg_data;
    logic        in_valid, in_hsync, in_vsync, in_de;
    logic [23:0] in_pix;
    logic        out_valid, out_hsync, out_vsync, out_de;
    logic [23:0] out_pix;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int pend_m [24];
    int work_m [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_matrix u_csc_matrix (
        .clk(clk), .rst(rst), .csc_en(csc_en), .swap_en(swap_en),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_de(in_de),
        .in_pix(in_pix), .out_valid(out_valid), .out_hsync(out_hsync),
        .out_vsync(out_vsync), .out_de(out_de), .out_pix(out_pix)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wval(int w);
        int mag = w & 'hFFF;
        return ((w & 'h1000) != 0) ? -mag : mag;
    endfunction

    function automatic int model(int c0, int c1, int c2, bit en, bit swp);
        int in_c [3];
        int res [3];
        int acc;
        in_c = '{c0, c1, c2};
        for (int i = 0; i < 3; i++) begin
            acc = wval(work_m[i*4+3]) * 1024 + 512;
            for (int j = 0; j < 3; j++)
                acc += wval(work_m[i*4+j]) * in_c[j];
            acc = acc >>> 10;
            if (acc < 0) acc = 0;
            if (acc > 255) acc = 255;
            res[i] = en ? acc : in_c[i];
        end
        if (swp) begin
            acc = res[0]; res[0] = res[2]; res[2] = acc;
        end
        return (res[2] << 16) | (res[1] << 8) | res[0];
    endfunction

    task automatic wr_byte(int addr, int data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 5'(addr); cfg_data = 8'(data);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (addr < 24) pend_m[addr] = data;
    endtask

    task automatic load_bank(input int w [12]);
        for (int k = 0; k < 12; k++) begin
            wr_byte(2*k, (w[k] >> 8) & 'hFF);
            wr_byte(2*k+1, w[k] & 'hFF);
        end
    endtask

    task automatic latch_model();
        for (int k = 0; k < 12; k++)
            work_m[k] = (pend_m[2*k] << 8) | pend_m[2*k+1];
    endtask

    task automatic frame_start();
        @(negedge clk);
        in_vsync = 1'b1;
        latch_model();
        @(negedge clk);
        in_vsync = 1'b0;
    endtask

    // One pixel in, result sampled after the third rising edge.
    task automatic send_pix(string req, int c0, int c1, int c2, bit en, bit swp,
                            bit vs, int exp);
        @(negedge clk);
        in_pix = 24'((c2 << 16) | (c1 << 8) | c0);
        csc_en = en; swap_en = swp; in_valid = 1'b1; in_de = 1'b1; in_vsync = vs;
        if (vs) latch_model();
        @(negedge clk);
        in_valid = 1'b0; in_de = 1'b0; in_vsync = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(req, int'(out_pix), exp);
        check(req, int'(out_valid), 1);
    endtask

    task automatic t_reset();
        check("R1", int'(out_pix), 0);
        check("R1", int'({out_valid, out_hsync, out_vsync, out_de}), 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b1; in_hsync = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_hsync = 1'b0;
        @(negedge clk);
        check("R2", int'({out_valid, out_hsync}), 0);
        @(negedge clk);
        check("R2", int'({out_valid, out_hsync, out_vsync, out_de}), 'b1100);
    endtask

    task automatic t_limited();
        load_bank('{'h036F, 0, 0, 'h0010,
                    0, 'h036F, 0, 'h0010,
                    0, 0, 'h036F, 'h0010});
        frame_start();
        send_pix("R8", 0, 0, 0, 1, 0, 0, 'h101010);
        send_pix("R8", 255, 255, 255, 1, 0, 0, 'hEBEBEB);
        send_pix("R4", 100, 50, 200, 1, 0, 0, model(100, 50, 200, 1, 0));
    endtask

    task automatic t_bypass_swap();
        send_pix("R3", 17, 99, 250, 0, 0, 0, 'hFA6311);
        send_pix("R9", 1, 2, 3, 0, 1, 0, 'h010203);
        send_pix("R9", 0, 100, 255, 1, 1, 0, model(0, 100, 255, 1, 1));
    endtask

    task automatic t_ycbcr();
        load_bank('{'h0107, 'h0204, 'h0064, 'h0010,
                    'h1098, 'h112A, 'h01C2, 'h0080,
                    'h01C2, 'h1179, 'h1049, 'h0080});
        frame_start();
        send_pix("R11", 128, 128, 128, 1, 0, 0, 'h808000 | (model(128,128,128,1,0) & 'hFF));
        send_pix("R11", 255, 255, 255, 1, 0, 0, 'h8080EB);
        send_pix("R5", 200, 30, 90, 1, 0, 0, model(200, 30, 90, 1, 0));
    endtask

    task automatic t_mapping();
        load_bank('{0, 0, 0, 'h1005,
                    0, 0, 'h0400, 0,
                    0, 0, 0, 'h0007});
        frame_start();
        send_pix("R4", 10, 20, 30, 1, 0, 0, 'h071E00);
        wr_byte(31, 'hFF);
        send_pix("R4", 10, 20, 30, 1, 0, 1, 'h071E00);
    endtask

    task automatic t_round();
        load_bank('{'h0200, 0, 0, 0,
                    'h1200, 0, 0, 'h000A,
                    'h0155, 0, 0, 0});
        frame_start();
        send_pix("R6", 1, 0, 0, 1, 0, 0, 'h000A01);
        send_pix("R6", 3, 0, 0, 1, 0, 0, 'h010902);
    endtask

    task automatic t_clamp();
        load_bank('{'h0800, 0, 0, 0,
                    'h1400, 0, 0, 0,
                    'h0400, 0, 0, 'h0080});
        frame_start();
        send_pix("R7", 200, 0, 0, 1, 0, 0, 'hFF00FF);
        send_pix("R7", 50, 0, 0, 1, 0, 0, 'hB20064);
    endtask

    task automatic t_deferred();
        load_bank('{'h0400, 0, 0, 0,
                    0, 'h0400, 0, 0,
                    0, 0, 'h0400, 0});
        send_pix("R10", 10, 20, 30, 1, 0, 0, 'h8A0014);
        send_pix("R10", 10, 20, 30, 1, 0, 1, 'h1E140A);
        send_pix("R10", 10, 20, 30, 1, 0, 0, 'h1E140A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 24; k++) pend_m[k] = 0;
        for (int k = 0; k < 12; k++) work_m[k] = 0;
        rst = 1'b1; csc_en = 1'b0; swap_en = 1'b0; cfg_wr_en = 1'b0;
        cfg_addr = '0; cfg_data = '0; in_valid = 1'b0; in_hsync = 1'b0;
        in_vsync = 1'b0; in_de = 1'b0; in_pix = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_limited();
        t_bypass_swap();
        t_ycbcr();
        t_mapping();
        t_round();
        t_clamp();
        t_deferred();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule